// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This block sits beside an I2C protocol engine and turns its single-cycle event pulses into sticky flags. Software sees the flags through a status register, enables them through a mask register, and learns which enabled event to serve next by reading a vector register. The vector register returns a small numeric code. A single interrupt request line is high while any enabled flag is pending.

There are seven events: arbitration lost, NACK received, register-access ready, receive data ready, transmit ready, stop detected and addressed as target. A flag is cleared in one of three ways. Software can write 1 to its status bit. A vector read clears the flag it reports. A data-register access clears the receive-ready or transmit-ready flag. Two live bus conditions, bus busy and receive shift full, also appear in the status word but are not flags.

The register port is a plain strobe interface. Read data is combinational from the address and the read strobe. Every side effect of a read or write takes place at the clock edge that ends the access. While the engine's run input is low, all flags are forced clear and stay clear.

Top module: `i2cev_unit`

## Requirements
- R1: After reset the mask register, every flag, the vector code and `irq` are all 0.
- R2: Each `evt_in` bit k sets flag k at the next clock edge. The bits are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as target. A set in the same cycle as any clear of that flag wins.
- R3: A write to the status register (offset 0x08) clears each flag whose bit in `reg_wdata` is 1. Flags written with 0 keep their value.
- R4: Status bit 11 shows `rx_shift_full` and bit 12 shows `bus_busy`, both live. Status bits 0..6 hold flags 0..6. All other status bits read 0. Writes do not affect bits 11 and 12.
- R5: The mask register (offset 0x04) holds enable bit k for flag k in bits 0..6. It is written in full by a write and reads back in bits 0..6, with bits above 6 reading 0.
- R6: The vector register (offset 0x28) reads k+1 for the lowest k whose flag is set and whose mask bit is 1. It reads 0 when no such k exists. Masked flags never appear.
- R7: A vector read that returns code 1, 2, 3, 6 or 7 clears that flag at the edge ending the read. Codes 4 and 5 leave their flag set.
- R8: A read of the receive data offset 0x18 clears flag 3. A write of the transmit data offset 0x20 clears flag 4. Neither access has any other effect.
- R9: `irq` is 1 exactly when at least one flag is both set and enabled, and it agrees with the vector code being nonzero.
- R10: While `core_run` is low, all flags clear at the next edge and stay clear. Events are ignored in that state. The mask register keeps its value.
- R11: `reg_rdata` is 0 whenever `reg_rd` is low or the address matches no register. Offsets 0x18 and 0x20 also read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_run | input | 1 | Engine run bit; low holds all flags clear |
| evt_in | input | 7 | Event pulses, bit k sets flag k |
| bus_busy | input | 1 | Live bus-busy level, shown in status bit 12 |
| rx_shift_full | input | 1 | Live receive-shift-full level, shown in status bit 11 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 7 | Write data for the flag and mask fields |
| reg_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request, high while an enabled flag is pending |

## Verification
Read data and the vector code are due in the same cycle as the read strobe, combinationally from the current flags and mask. Event sets, write-1 clears, vector-read clears and data-access clears become visible one clock edge after the strobe or pulse. `irq` follows at that same edge because it is derived only from the registered flags and mask. The bench drives inputs just after the falling edge, compares `reg_rdata` and `irq` with its behavioural model 2 ns later, and then advances the model at the rising edge. Each access is therefore judged on the cycle it is presented, and its side effects are judged on the following cycle.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;

    localparam int EVT_N        = 7;
    localparam int IDX_AL       = 0;
    localparam int IDX_NACK     = 1;
    localparam int IDX_ARDY     = 2;
    localparam int IDX_RRDY     = 3;
    localparam int IDX_XRDY     = 4;
    localparam int IDX_STOP     = 5;
    localparam int IDX_ASTGT    = 6;
    localparam int STAT_RSF_BIT = 11;
    localparam int STAT_BB_BIT  = 12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_VEC,
        SEL_RXD,
        SEL_TXD
    } reg_sel_e;

endpackage

// File: rtl/i2cev_addr_decode.sv
module i2cev_addr_decode
    import i2cev_pkg::*;
#(
    parameter int             ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_MASK = 'h04,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'h08,
    parameter logic [ADDR_W-1:0] OFS_VEC  = 'h28,
    parameter logic [ADDR_W-1:0] OFS_RXD  = 'h18,
    parameter logic [ADDR_W-1:0] OFS_TXD  = 'h20
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == OFS_MASK)      sel = SEL_MASK;
        else if (addr == OFS_STAT) sel = SEL_STAT;
        else if (addr == OFS_VEC)  sel = SEL_VEC;
        else if (addr == OFS_RXD)  sel = SEL_RXD;
        else if (addr == OFS_TXD)  sel = SEL_TXD;
        else                       sel = SEL_NONE;
    end

endmodule

// File: rtl/i2cev_flag_bank.sv
module i2cev_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar k = 0; k < N; k++) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= 1'b0;
            else if (!run)      q <= 1'b0;
            else if (set_i[k])  q <= 1'b1;
            else if (clr_i[k])  q <= 1'b0;
        end
        assign flag_o[k] = q;
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((flag_o & $past(set_i)) == $past(set_i))); // R2

    AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (flag_o == '0)); // R10

endmodule

// File: rtl/i2cev_prio_enc.sv
module i2cev_prio_enc #(
    parameter int N      = 7,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      req,
    output logic [N-1:0]      grant,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        grant = '0;
        code  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                grant    = '0;
                grant[k] = 1'b1;
                code     = CODE_W'(k + 1);
            end
        end
    end

    always_comb begin
        if (!$isunknown(req)) begin
            AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R6
        end
    end

endmodule

// File: rtl/i2cev_unit.sv
module i2cev_unit
    import i2cev_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] OFS_MASK = 'h04,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'h08,
    parameter logic [ADDR_W-1:0] OFS_VEC  = 'h28,
    parameter logic [ADDR_W-1:0] OFS_RXD  = 'h18,
    parameter logic [ADDR_W-1:0] OFS_TXD  = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_run,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic              bus_busy,
    input  logic              rx_shift_full,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [EVT_N-1:0]  reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int VEC_W = $clog2(EVT_N + 1);
    localparam logic [EVT_N-1:0] KEEP_ON_VEC =
        EVT_N'((1 << IDX_RRDY) | (1 << IDX_XRDY));

    reg_sel_e         sel;
    logic [EVT_N-1:0] mask_q;
    logic [EVT_N-1:0] flags;
    logic [EVT_N-1:0] grant;
    logic [EVT_N-1:0] clr_all;
    logic [VEC_W-1:0] code;

    i2cev_addr_decode #(
        .ADDR_W  (ADDR_W),
        .OFS_MASK(OFS_MASK),
        .OFS_STAT(OFS_STAT),
        .OFS_VEC (OFS_VEC),
        .OFS_RXD (OFS_RXD),
        .OFS_TXD (OFS_TXD)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mask_q <= '0;
        else if (reg_wr && sel == SEL_MASK) mask_q <= reg_wdata;
    end

    always_comb begin
        clr_all = '0;
        if (reg_wr && sel == SEL_STAT) clr_all = clr_all | reg_wdata;
        if (reg_rd && sel == SEL_VEC)  clr_all = clr_all | (grant & ~KEEP_ON_VEC);
        if (reg_rd && sel == SEL_RXD)  clr_all[IDX_RRDY] = 1'b1;
        if (reg_wr && sel == SEL_TXD)  clr_all[IDX_XRDY] = 1'b1;
    end

    i2cev_flag_bank #(.N(EVT_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (core_run),
        .set_i (evt_in),
        .clr_i (clr_all),
        .flag_o(flags)
    );

    i2cev_prio_enc #(.N(EVT_N), .CODE_W(VEC_W)) u_prio (
        .req  (flags & mask_q),
        .grant(grant),
        .code (code)
    );

    assign irq = |(flags & mask_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (sel)
                SEL_MASK: reg_rdata[EVT_N-1:0] = mask_q;
                SEL_STAT: begin
                    reg_rdata[EVT_N-1:0]   = flags;
                    reg_rdata[STAT_RSF_BIT] = rx_shift_full;
                    reg_rdata[STAT_BB_BIT]  = bus_busy;
                end
                SEL_VEC:  reg_rdata[VEC_W-1:0] = code;
                default:  reg_rdata = '0;
            endcase
        end
    end

    AST_IRQ_VS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (code != '0)); // R9

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && reg_wr && sel == SEL_STAT)
        |=> ((flags & $past(reg_wdata & ~evt_in)) == '0)); // R3

    AST_VEC_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && reg_rd && sel == SEL_VEC && code != '0 &&
         (grant & KEEP_ON_VEC) == '0 && (grant & evt_in) == '0)
        |=> ((flags & $past(grant)) == '0)); // R7

    AST_VEC_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && reg_rd && sel == SEL_VEC && (grant & KEEP_ON_VEC) != '0)
        |=> ((flags & $past(grant)) == $past(grant))); // R7

    AST_RXD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && reg_rd && sel == SEL_RXD && !evt_in[IDX_RRDY])
        |=> !flags[IDX_RRDY]); // R8

endmodule

// File: tb/i2cev_unit_bench.sv
module i2cev_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_run = 1'b0;
    logic [6:0]  evt_in = '0;
    logic        bus_busy = 1'b0;
    logic        rx_shift_full = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [6:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit [6:0] m_flag = '0;
    bit [6:0] m_mask = '0;

    always #10 clk = ~clk;

    i2cev_unit u_i2cev_unit (
        .clk(clk), .rst_n(rst_n), .core_run(core_run), .evt_in(evt_in),
        .bus_busy(bus_busy), .rx_shift_full(rx_shift_full),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int exp_code();
        for (int k = 0; k < 7; k++)
            if (m_flag[k] && m_mask[k]) return k + 1;
        return 0;
    endfunction

    function automatic logic [15:0] exp_rdata();
        logic [15:0] v = '0;
        if (!reg_rd) return v;
        case (reg_addr)
            8'h04: v[6:0] = m_mask;
            8'h08: begin v[6:0] = m_flag; v[11] = rx_shift_full; v[12] = bus_busy; end
            8'h28: v = 16'(exp_code());
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(string tag);
        bit [6:0] clr = '0;
        int c;
        #2;
        check({tag, " irq"}, {15'b0, irq}, {15'b0, (m_flag & m_mask) != 0});
        check({tag, " rdata"}, reg_rdata, exp_rdata());
        @(posedge clk);
        c = exp_code();
        if (reg_wr && reg_addr == 8'h08) clr |= reg_wdata;
        if (reg_wr && reg_addr == 8'h20) clr[4] = 1'b1;
        if (reg_rd && reg_addr == 8'h18) clr[3] = 1'b1;
        if (reg_rd && reg_addr == 8'h28 && c != 0 && c != 4 && c != 5) clr[c-1] = 1'b1;
        if (reg_wr && reg_addr == 8'h04) m_mask = reg_wdata;
        m_flag = core_run ? ((m_flag & ~clr) | evt_in) : '0;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0; evt_in = '0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [15:0] exp, string tag);
        reg_rd = 1'b1; reg_addr = a;
        #1 check({tag, " direct"}, reg_rdata, exp);
        #0 tick(tag);
    endtask

    task automatic wr(logic [7:0] a, logic [6:0] d, string tag);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(tag);
    endtask

    task automatic pulse(logic [6:0] e, string tag);
        evt_in = e;
        tick(tag);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {15'b0, irq}, 16'h0);
        rst_n = 1'b1; core_run = 1'b1;
        @(negedge clk);
        rd_expect(8'h04, 16'h0000, "R1 mask");
        rd_expect(8'h08, 16'h0000, "R1 status");
        rd_expect(8'h28, 16'h0000, "R1 vector");

        wr(8'h04, 7'h7F, "R5 write mask");
        rd_expect(8'h04, 16'h007F, "R5 mask readback");
        wr(8'h04, 7'h15, "R5 write mask");
        rd_expect(8'h04, 16'h0015, "R5 mask readback");
        wr(8'h04, 7'h7F, "R5 write mask");

        // R2: each event lands on its own bit; R7 vector read returns and clears
        pulse(7'h20, "R2 stop");
        rd_expect(8'h08, 16'h0020, "R2 status bit5");
        rd_expect(8'h28, 16'h0006, "R6 code stop");
        rd_expect(8'h08, 16'h0000, "R7 stop cleared");
        pulse(7'h40, "R2 astgt");
        rd_expect(8'h28, 16'h0007, "R6 code astgt");
        rd_expect(8'h28, 16'h0000, "R7 astgt cleared");

        // R6 priority and R7/R8 data-ready handling
        pulse(7'h7F, "R2 all events");
        rd_expect(8'h28, 16'h0001, "R6 first al");
        rd_expect(8'h28, 16'h0002, "R6 then nack");
        rd_expect(8'h28, 16'h0003, "R6 then ardy");
        rd_expect(8'h28, 16'h0004, "R7 rrdy kept");
        rd_expect(8'h28, 16'h0004, "R7 rrdy still");
        rd_expect(8'h18, 16'h0000, "R8 rxd read");
        rd_expect(8'h28, 16'h0005, "R8 rrdy cleared");
        rd_expect(8'h28, 16'h0005, "R7 xrdy kept");
        wr(8'h20, 7'h00, "R8 txd write");
        rd_expect(8'h28, 16'h0006, "R8 xrdy cleared");
        rd_expect(8'h28, 16'h0007, "R6 astgt last");
        rd_expect(8'h28, 16'h0000, "R6 none left");

        // R6/R9 masking
        wr(8'h04, 7'h10, "R5 mask xrdy only");
        pulse(7'h11, "R2 al and xrdy");
        rd_expect(8'h28, 16'h0005, "R6 masked al hidden");
        check("R9 irq high", {15'b0, irq}, 16'h1);
        wr(8'h04, 7'h00, "R5 mask none");
        check("R9 irq low when masked", {15'b0, irq}, 16'h0);
        rd_expect(8'h28, 16'h0000, "R6 all masked");
        rd_expect(8'h08, 16'h0011, "R6 flags still set");

        // R3 write-1-to-clear
        pulse(7'h07, "R2 set low three");
        wr(8'h08, 7'h00, "R3 write zero");
        rd_expect(8'h08, 16'h0017, "R3 zero keeps");
        wr(8'h08, 7'h05, "R3 clear bits 0,2");
        rd_expect(8'h08, 16'h0012, "R3 partial clear");
        // R2 set beats clear
        reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 7'h02; evt_in = 7'h02;
        tick("R2 set vs clear");
        rd_expect(8'h08, 16'h0012, "R2 set wins");
        wr(8'h08, 7'h7F, "R3 clear all");
        rd_expect(8'h08, 16'h0000, "R3 all clear");

        // R4 live bits
        bus_busy = 1'b1; rx_shift_full = 1'b1;
        rd_expect(8'h08, 16'h1800, "R4 both live");
        rx_shift_full = 1'b0;
        rd_expect(8'h08, 16'h1000, "R4 busy only");
        wr(8'h08, 7'h7F, "R4 write ignored");
        rd_expect(8'h08, 16'h1000, "R4 still busy");
        bus_busy = 1'b0;

        // R10 run low
        wr(8'h04, 7'h7F, "R5 mask all");
        pulse(7'h09, "R2 set two");
        core_run = 1'b0;
        pulse(7'h7F, "R10 events while held");
        rd_expect(8'h08, 16'h0000, "R10 flags held clear");
        check("R10 irq low", {15'b0, irq}, 16'h0);
        rd_expect(8'h04, 16'h007F, "R10 mask kept");
        core_run = 1'b1;

        // R11 unmapped / idle reads
        pulse(7'h01, "R2 al");
        rd_expect(8'h3C, 16'h0000, "R11 unmapped");
        rd_expect(8'h20, 16'h0000, "R11 txd reads zero");
        reg_addr = 8'h08;
        #1 check("R11 no strobe", reg_rdata, 16'h0000);
        #0 tick("R11 idle");

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom;
            case (r[10:8])
                3'd0: reg_addr = 8'h04;
                3'd1: reg_addr = 8'h08;
                3'd2, 3'd3: reg_addr = 8'h28;
                3'd4: reg_addr = 8'h18;
                3'd5: reg_addr = 8'h20;
                default: reg_addr = 8'h44;
            endcase
            reg_rd = r[11];
            reg_wr = r[12] & r[13];
            reg_wdata = r[20:14];
            evt_in = (r[22:21] == 2'd0) ? r[29:23] : 7'h00;
            core_run = (r[31:27] != 5'd0);
            bus_busy = r[30];
            rx_shift_full = r[26];
            tick("R6 mixed");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule